// File: doc/BRIEF.md
# SDIO Multi-Block Read Sequencer with Read-Wait Suspension

This block sequences the data phase of a multi-block read on an SD/SDIO host. A start request latches a block size in bytes and a block count. Each data strobe then advances a byte counter inside the current block. When the byte counter reaches the block size, it rolls back to zero and the completed-block counter steps. A single-cycle done pulse marks the final byte of the final block.

While a transfer runs, the host can suspend it with a read-wait request. During the suspension the byte counter, the block counter and the busy status hold their values. The card clock enable stays high, and command requests go out on the command path just as they do when the sequencer is idle. A read-wait exit request returns the sequencer to counting from the held values, and the transfer then runs to completion. CRC checking and the pad drivers sit outside this block.

Top module: `sdio_rdwait_seq`

## Requirements
- R1: With blk_size_i and blk_count_i both nonzero, a start_i sampled while idle clears both counters and raises busy_o and clk_en_o on the next cycle. A start_i with a zero size or a zero count is ignored. A start_i sampled while busy is ignored.
- R2: While counting, each sampled data_stb_i increments byte_cnt_o by one.
- R3: A strobe that brings the byte count up to the latched block size sets byte_cnt_o to 0 and increments blk_cnt_o. byte_cnt_o always stays below the latched block size.
- R4: The strobe that completes the last byte of the last block produces a done_o pulse exactly one cycle long, one cycle later. In that same cycle busy_o falls and both counters read 0.
- R5: A rw_enter_i sampled while counting raises rw_active_o. For as long as rw_active_o stays high, byte_cnt_o, blk_cnt_o and busy_o hold their values.
- R6: Data strobes sampled during read-wait are ignored. So is a strobe sampled in the same cycle as rw_enter_i.
- R7: clk_en_o equals busy_o, so it stays high for the whole read-wait period.
- R8: cmd_ok_o is high when idle or in read-wait and low while counting. cmd_issue_o equals cmd_req_i gated by cmd_ok_o, with no cycle of delay.
- R9: A rw_exit_i sampled during read-wait clears rw_active_o. Counting then resumes from the held values and runs on to the done pulse.
- R10: A rw_enter_i sampled while idle is ignored, and rw_active_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a multi-block read |
| blk_size_i | input | BSIZE_W | Bytes per block, latched at start |
| blk_count_i | input | BCNT_W | Blocks in the transfer, latched at start |
| data_stb_i | input | 1 | One received byte |
| rw_enter_i | input | 1 | Request read-wait suspension |
| rw_exit_i | input | 1 | Release read-wait suspension |
| cmd_req_i | input | 1 | Request to issue a command |
| byte_cnt_o | output | BSIZE_W | Byte index within the current block |
| blk_cnt_o | output | BCNT_W | Blocks completed so far |
| busy_o | output | 1 | Transfer in progress, including read-wait |
| done_o | output | 1 | One-cycle completion pulse |
| rw_active_o | output | 1 | Read-wait suspension in force |
| cmd_ok_o | output | 1 | Command issue permitted |
| cmd_issue_o | output | 1 | Command request forwarded |
| clk_en_o | output | 1 | Card clock enable |

## Verification
The bench builds the block with BSIZE_W=4 and BCNT_W=3, so blocks hold 1 to 15 bytes and a transfer has 1 to 7 blocks. At these widths every byte wrap and every final-block completion is reached within tens of strobes. The largest configuration, 15 bytes by 7 blocks with a suspension in the middle, finishes in about a hundred cycles. Random runs with short blocks produce read-wait entries on the first byte, on a block boundary, and in the cycle just before completion.

// File: rtl/sdio_rw_pkg.sv
package sdio_rw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } xfer_st_e;
endpackage

// File: rtl/sdio_rw_counters.sv
module sdio_rw_counters #(
  parameter int BSIZE_W = 12,
  parameter int BCNT_W  = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               adv_i,
  input  logic [BSIZE_W-1:0] size_i,
  input  logic [BCNT_W-1:0]  count_i,
  output logic [BSIZE_W-1:0] byte_o,
  output logic [BCNT_W-1:0]  blk_o,
  output logic               last_o
);
  localparam logic [BSIZE_W-1:0] BONE = BSIZE_W'(1);
  localparam logic [BCNT_W-1:0]  KONE = BCNT_W'(1);

  logic [BSIZE_W-1:0] byte_q, size_q;
  logic [BCNT_W-1:0]  blk_q, count_q;
  logic byte_end, blk_end;

  assign byte_end = (byte_q == size_q - BONE);
  assign blk_end  = (blk_q == count_q - KONE);
  assign last_o   = byte_end && blk_end;
  assign byte_o   = byte_q;
  assign blk_o    = blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q  <= '0;
      blk_q   <= '0;
      size_q  <= '0;
      count_q <= '0;
    end else if (clr_i) begin
      byte_q  <= '0;
      blk_q   <= '0;
      size_q  <= size_i;
      count_q <= count_i;
    end else if (adv_i) begin
      if (byte_end) begin
        byte_q <= '0;
        blk_q  <= blk_end ? '0 : blk_q + KONE;
      end else begin
        byte_q <= byte_q + BONE;
      end
    end
  end

  // R3
  byte_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_q != '0) |-> (byte_q < size_q));
endmodule

// File: rtl/sdio_rw_fsm.sv
module sdio_rw_fsm
  import sdio_rw_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     cfg_ok_i,
  input  logic     stb_i,
  input  logic     enter_i,
  input  logic     exit_i,
  input  logic     last_i,
  output xfer_st_e st_o,
  output logic     clr_o,
  output logic     adv_o,
  output logic     done_o
);
  xfer_st_e st_q, st_d;
  logic done_q;

  assign clr_o  = (st_q == ST_IDLE) && start_i && cfg_ok_i;
  // read-wait entry wins over a coincident strobe
  assign adv_o  = (st_q == ST_RUN) && stb_i && !enter_i;
  assign st_o   = st_q;
  assign done_o = done_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (clr_o) st_d = ST_RUN;
      ST_RUN: begin
        if (enter_i)             st_d = ST_WAIT;
        else if (adv_o && last_i) st_d = ST_IDLE;
      end
      ST_WAIT: if (exit_i) st_d = ST_RUN;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= adv_o && last_i;
    end
  end

  // R10
  idle_rw_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |=> (st_q != ST_WAIT));
  // R4
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R4
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (st_q == ST_IDLE));
endmodule

// File: rtl/sdio_rdwait_seq.sv
module sdio_rdwait_seq
  import sdio_rw_pkg::*;
#(
  parameter int BSIZE_W = 12,
  parameter int BCNT_W  = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [BSIZE_W-1:0] blk_size_i,
  input  logic [BCNT_W-1:0]  blk_count_i,
  input  logic               data_stb_i,
  input  logic               rw_enter_i,
  input  logic               rw_exit_i,
  input  logic               cmd_req_i,
  output logic [BSIZE_W-1:0] byte_cnt_o,
  output logic [BCNT_W-1:0]  blk_cnt_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               rw_active_o,
  output logic               cmd_ok_o,
  output logic               cmd_issue_o,
  output logic               clk_en_o
);
  xfer_st_e st;
  logic clr, adv, last, cfg_ok;

  assign cfg_ok = (blk_size_i != '0) && (blk_count_i != '0);

  sdio_rw_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .cfg_ok_i(cfg_ok),
    .stb_i   (data_stb_i),
    .enter_i (rw_enter_i),
    .exit_i  (rw_exit_i),
    .last_i  (last),
    .st_o    (st),
    .clr_o   (clr),
    .adv_o   (adv),
    .done_o  (done_o)
  );

  sdio_rw_counters #(.BSIZE_W(BSIZE_W), .BCNT_W(BCNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .adv_i  (adv),
    .size_i (blk_size_i),
    .count_i(blk_count_i),
    .byte_o (byte_cnt_o),
    .blk_o  (blk_cnt_o),
    .last_o (last)
  );

  assign busy_o      = (st != ST_IDLE);
  assign rw_active_o = (st == ST_WAIT);
  assign cmd_ok_o    = (st != ST_RUN);
  assign cmd_issue_o = cmd_req_i && cmd_ok_o;
  // card clock never gated by read-wait
  assign clk_en_o    = busy_o;

  // R5
  rw_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rw_active_o |=> ($stable(byte_cnt_o) && $stable(blk_cnt_o) && busy_o));
  // R7
  rw_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rw_active_o |-> clk_en_o);
  // R8
  rw_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rw_active_o && cmd_req_i) |-> cmd_issue_o);
  // R6
  rw_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rw_active_o |=> !done_o);
endmodule

// File: tb/sdio_rdwait_seq_bench.sv
module sdio_rdwait_seq_bench;
  localparam int BSW = 4;
  localparam int BCW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, stb = 0, enter = 0, exitr = 0, cmd = 0;
  logic [BSW-1:0] size = '0;
  logic [BCW-1:0] count = '0;
  logic [BSW-1:0] byte_cnt;
  logic [BCW-1:0] blk_cnt;
  logic busy, done, rw, cmd_ok, cmd_issue, clk_en;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model
  int m_st = 0, m_byte = 0, m_blk = 0, m_size = 0, m_cnt = 0;
  bit m_done = 0;

  always #10 clk = ~clk;

  sdio_rdwait_seq #(.BSIZE_W(BSW), .BCNT_W(BCW)) u_sdio_rdwait_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .blk_size_i(size),
    .blk_count_i(count), .data_stb_i(stb), .rw_enter_i(enter),
    .rw_exit_i(exitr), .cmd_req_i(cmd), .byte_cnt_o(byte_cnt),
    .blk_cnt_o(blk_cnt), .busy_o(busy), .done_o(done), .rw_active_o(rw),
    .cmd_ok_o(cmd_ok), .cmd_issue_o(cmd_issue), .clk_en_o(clk_en));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_byte = 0; m_blk = 0; m_size = 0; m_cnt = 0; m_done = 0;
    end else begin
      m_done = 0;
      case (m_st)
        0: if (start && size != 0 && count != 0) begin
             m_st = 1; m_byte = 0; m_blk = 0; m_size = size; m_cnt = count;
           end
        1: if (enter) m_st = 2;
           else if (stb) begin
             m_byte++;
             if (m_byte == m_size) begin
               m_byte = 0; m_blk++;
               if (m_blk == m_cnt) begin m_blk = 0; m_done = 1; m_st = 0; end
             end
           end
        default: if (exitr) m_st = 1;
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R2 byte_cnt", byte_cnt, m_byte);
    chk("R3 blk_cnt", blk_cnt, m_blk);
    chk("R4 done", done, m_done);
    chk("R5 busy", busy, m_st != 0);
    chk("R5 rw_active", rw, m_st == 2);
    chk("R7 clk_en", clk_en, m_st != 0);
    chk("R8 cmd_ok", cmd_ok, m_st != 1);
    chk("R8 cmd_issue", cmd_issue, cmd && (m_st != 1));
  endtask

  task automatic step(input logic s, input logic d, input logic e,
                      input logic x, input logic c);
    @(negedge clk);
    start = s; stb = d; enter = e; exitr = x; cmd = c;
    #1 compare();
  endtask

  task automatic idle_step();
    step(0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset busy", busy, 0);
    chk("R1 reset byte", byte_cnt, 0);
    chk("R1 reset clk_en", clk_en, 0);

    // R10: read-wait while idle
    step(0, 0, 1, 0, 0);
    idle_step();
    chk("R10 idle enter ignored", rw, 0);

    // R1: zero size start ignored
    size = 0; count = 2;
    step(1, 0, 0, 0, 0);
    idle_step();
    chk("R1 zero size ignored", busy, 0);

    // main directed: 3 bytes x 2 blocks with suspension
    size = 3; count = 2;
    step(1, 0, 0, 0, 0);
    idle_step();
    chk("R1 busy after start", busy, 1);
    chk("R1 clk_en after start", clk_en, 1);
    step(0, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(1, 1, 1, 0, 0);          // enter wins over strobe, start ignored
    step(0, 1, 0, 0, 1);
    chk("R6 strobe on enter ignored", byte_cnt, 2);
    chk("R8 cmd in read-wait", cmd_issue, 1);
    step(0, 1, 0, 0, 1);
    step(0, 1, 0, 0, 0);
    chk("R6 strobes in read-wait", byte_cnt, 2);
    chk("R5 rw_active held", rw, 1);
    chk("R7 clk_en in read-wait", clk_en, 1);
    step(0, 0, 0, 1, 0);
    step(0, 1, 0, 0, 1);
    chk("R8 cmd blocked while counting", cmd_issue, 0);
    step(0, 1, 0, 0, 0);
    chk("R9 resume wraps block", byte_cnt, 0);
    chk("R9 resume block count", blk_cnt, 1);
    step(0, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R4 done pulse", done, 1);
    chk("R4 idle at done", busy, 0);
    idle_step();
    chk("R4 done one cycle", done, 0);

    // single byte, single block
    size = 1; count = 1;
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    idle_step();
    chk("R4 1x1 done", done, 1);

    // largest configuration with a mid-transfer suspension
    size = 15; count = 7;
    step(1, 0, 0, 0, 0);
    for (int i = 0; i < 105; i++) begin
      if (i == 50) begin
        step(0, 0, 1, 0, 0);
        for (int k = 0; k < 4; k++) step(0, 1, 0, 0, 1);
        step(0, 0, 0, 1, 0);
      end
      step(0, 1, 0, 0, 0);
    end
    idle_step();
    chk("R9 long transfer done", done, 1);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      if (!busy) begin
        size = BSW'(1 + $urandom % 4);
        count = BCW'(1 + $urandom % 3);
      end
      step(($urandom % 6) == 0, ($urandom % 3) != 0, ($urandom % 9) == 0,
           ($urandom % 4) == 0, ($urandom % 2) == 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule